// File: doc/BRIEF.md
# Receive Address Match Filter

This block sits on the character path of a serial receiver, between the point where complete characters appear and the receive buffer, on a multidrop line where several nodes share one receive wire. A character whose top bit is set is an address character. Every other character is a data character. Software programs one or more match values and gives each its own enable bit. Each address character is compared against the enabled values. The outcome sets a one-bit pass/drop state, and that state decides whether the data characters that follow reach the buffer.

The configuration port has a write strobe, an address, write data and combinational read data. The match values sit at configuration addresses 0 to NUM_MATCH-1. The enable bits sit at address NUM_MATCH, where bit i enables match value i. Characters enter with a valid strobe. Accepted characters leave one cycle later, unchanged, with their own valid strobe. When every enable is clear, the filter is transparent.

Top module: `rxaddr_filter`

## Requirements
- R1: After reset, all match values and all enable bits read as zero, and no character is output.
- R2: A write to configuration address i (i < NUM_MATCH) sets match value i. A write to address NUM_MATCH sets the enables from the low NUM_MATCH bits of the write data. Reads return these values, with unused enable bits read as zero. Any other address reads as zero.
- R3: While all enable bits are zero, every input character is output unchanged on the next cycle.
- R4: When any enable is set, an address character (bit 7 = 1) equal to at least one enabled match value is output and sets the state to pass.
- R5: When any enable is set, an address character equal to no enabled match value is dropped and sets the state to drop. This includes a character equal only to a value whose enable is clear.
- R6: When any enable is set, a data character (bit 7 = 0) is output if and only if the state is pass. The state holds across any number of data characters until the next address character.
- R7: After reset, the state is drop, so with an enable set, data characters are dropped until a matching address arrives.
- R8: Configuration writes may occur during reception. A character arriving in the same cycle as a write is judged against the old values, and later characters are judged against the new ones.
- R9: Address characters that arrive while all enables are clear leave the pass/drop state unchanged.
- R10: The output valid strobe is high exactly one cycle after an accepted input character and low otherwise. The output data equals the accepted input character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Configuration address (AW = clog2(NUM_MATCH+1)) |
| cfg_wdata | input | DATA_W | Configuration write data |
| cfg_rdata | output | DATA_W | Configuration read data, combinational from cfg_addr |
| ch_valid | input | 1 | Input character strobe |
| ch_data | input | DATA_W | Input character, top bit marks an address |
| out_valid | output | 1 | Filtered character strobe |
| out_data | output | DATA_W | Filtered character |

## Verification
The only hidden state is the one-bit pass/drop flag. If it is wrong, the error shows on the first data character after the faulty address: a character is passed that should be dropped, or dropped that should be passed. The wrong output lasts until the next address character re-evaluates the flag. A fault in a match value or enable bit shows either on readback or on the next address character that equals the programmed value. So the bench sweeps every address code under every enable combination, and follows each address with a data character.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

   typedef enum logic {
      ST_DROP = 1'b0,
      ST_PASS = 1'b1
   } gate_e;

endpackage

// File: rtl/rxaf_regs.sv
module rxaf_regs #(
   parameter int DATA_W    = 8,
   parameter int NUM_MATCH = 2,
   parameter int AW        = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [AW-1:0]                 addr,
   input  logic [DATA_W-1:0]             wdata,
   output logic [DATA_W-1:0]             rdata,
   output logic [NUM_MATCH*DATA_W-1:0]   match_flat,
   output logic [NUM_MATCH-1:0]          en
);

   localparam int EN_ADDR = NUM_MATCH;

   logic [DATA_W-1:0]    match_q [NUM_MATCH];
   logic [NUM_MATCH-1:0] en_q;

   for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            match_q[i] <= '0;
         end else if (we && addr == AW'(i)) begin
            match_q[i] <= wdata;
         end
      end
      assign match_flat[i*DATA_W +: DATA_W] = match_q[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (we && addr == AW'(EN_ADDR)) begin
         en_q <= wdata[NUM_MATCH-1:0];
      end
   end

   assign en = en_q;

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_MATCH; i++) begin
         if (addr == AW'(i)) rdata = match_q[i];
      end
      if (addr == AW'(EN_ADDR)) rdata = DATA_W'(en_q);
   end

endmodule

// File: rtl/rxaf_compare.sv
module rxaf_compare #(
   parameter int DATA_W    = 8,
   parameter int NUM_MATCH = 2
) (
   input  logic [DATA_W-1:0]           ch_data,
   input  logic [NUM_MATCH*DATA_W-1:0] match_flat,
   input  logic [NUM_MATCH-1:0]        en,
   output logic                        is_addr,
   output logic                        hit,
   output logic                        bypass
);

   logic [NUM_MATCH-1:0] hit_vec;

   assign is_addr = ch_data[DATA_W-1];

   for (genvar i = 0; i < NUM_MATCH; i++) begin : g_cmp
      assign hit_vec[i] = en[i] && is_addr &&
                          (ch_data == match_flat[i*DATA_W +: DATA_W]);
   end

   assign hit    = |hit_vec;
   assign bypass = ~|en;

endmodule

// File: rtl/rxaf_gate.sv
module rxaf_gate
   import rxaf_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ch_valid,
   input  logic [DATA_W-1:0] ch_data,
   input  logic              is_addr,
   input  logic              hit,
   input  logic              bypass,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              pass
);

   gate_e state_q;
   logic  take;

   always_comb begin
      if (!ch_valid)    take = 1'b0;
      else if (bypass)  take = 1'b1;
      else if (is_addr) take = hit;
      else              take = (state_q == ST_PASS);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_DROP;
      end else if (ch_valid && !bypass && is_addr) begin
         state_q <= hit ? ST_PASS : ST_DROP;
      end
   end

   assign pass = (state_q == ST_PASS);

   if (REG_OUT) begin : g_reg_out
      logic              vld_q;
      logic [DATA_W-1:0] dat_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
         end else begin
            vld_q <= take;
            if (take) dat_q <= ch_data;
         end
      end
      assign out_valid = vld_q;
      assign out_data  = dat_q;
   end else begin : g_comb_out
      assign out_valid = take;
      assign out_data  = ch_data;
   end

endmodule

// File: rtl/rxaddr_filter.sv
module rxaddr_filter #(
   parameter int DATA_W    = 8,
   parameter int NUM_MATCH = 2,
   parameter bit REG_OUT   = 1'b1,
   localparam int AW       = $clog2(NUM_MATCH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [AW-1:0]     cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              ch_valid,
   input  logic [DATA_W-1:0] ch_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);

   if (DATA_W < 2) begin : g_bad_width
      $error("rxaddr_filter: DATA_W must be at least 2");
   end
   if (NUM_MATCH < 1 || NUM_MATCH > DATA_W) begin : g_bad_count
      $error("rxaddr_filter: NUM_MATCH must lie in 1..DATA_W");
   end

   logic [NUM_MATCH*DATA_W-1:0] match_w;
   logic [NUM_MATCH-1:0]        en_w;
   logic                        is_addr_w;
   logic                        hit_w;
   logic                        bypass_w;
   logic                        pass_w;

   rxaf_regs #(
      .DATA_W   (DATA_W),
      .NUM_MATCH(NUM_MATCH),
      .AW       (AW)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .addr      (cfg_addr),
      .wdata     (cfg_wdata),
      .rdata     (cfg_rdata),
      .match_flat(match_w),
      .en        (en_w)
   );

   rxaf_compare #(
      .DATA_W   (DATA_W),
      .NUM_MATCH(NUM_MATCH)
   ) u_cmp (
      .ch_data   (ch_data),
      .match_flat(match_w),
      .en        (en_w),
      .is_addr   (is_addr_w),
      .hit       (hit_w),
      .bypass    (bypass_w)
   );

   rxaf_gate #(
      .DATA_W (DATA_W),
      .REG_OUT(REG_OUT)
   ) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .ch_valid (ch_valid),
      .ch_data  (ch_data),
      .is_addr  (is_addr_w),
      .hit      (hit_w),
      .bypass   (bypass_w),
      .out_valid(out_valid),
      .out_data (out_data),
      .pass     (pass_w)
   );

endmodule

// File: rtl/rxaf_checker.sv
module rxaf_checker #(
   parameter int DATA_W    = 8,
   parameter int NUM_MATCH = 2,
   parameter bit REG_OUT   = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 ch_valid,
   input logic [DATA_W-1:0]    ch_data,
   input logic                 out_valid,
   input logic [DATA_W-1:0]    out_data,
   input logic [NUM_MATCH-1:0] en,
   input logic                 hit,
   input logic                 pass
);

   if (REG_OUT) begin : g_chk
      // R10: no output without an input one cycle earlier
      a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> $past(ch_valid));
      // R10: output carries the accepted character unchanged
      a_r10_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> out_data == $past(ch_data));
      // R3: transparent while all enables are clear
      a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_valid && en == '0) |=> out_valid);
      // R4: matching address passes and opens the gate
      a_r4_hit_passes: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_valid && en != '0 && ch_data[DATA_W-1] && hit) |=> (out_valid && pass));
      // R5: failing address is dropped and closes the gate
      a_r5_miss_drops: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_valid && en != '0 && ch_data[DATA_W-1] && !hit) |=> (!out_valid && !pass));
      // R6: data characters follow the held state
      a_r6_data_follows: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_valid && en != '0 && !ch_data[DATA_W-1]) |=> (out_valid == $past(pass)));
   end

   // R9: state moves only on an address character under active filtering
   a_r9_state_held: assert property (@(posedge clk) disable iff (!rst_n)
      !(ch_valid && en != '0 && ch_data[DATA_W-1]) |=> $stable(pass));

endmodule

bind rxaddr_filter rxaf_checker #(
   .DATA_W   (DATA_W),
   .NUM_MATCH(NUM_MATCH),
   .REG_OUT  (REG_OUT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ch_valid (ch_valid),
   .ch_data  (ch_data),
   .out_valid(out_valid),
   .out_data (out_data),
   .en       (en_w),
   .hit      (hit_w),
   .pass     (pass_w)
);

// File: tb/rxaddr_filter_test.sv
module rxaddr_filter_test;

   localparam logic [7:0] M0 = 8'h85;
   localparam logic [7:0] M1 = 8'hA3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       ch_valid = 1'b0;
   logic [7:0] ch_data = '0;
   logic       out_valid;
   logic [7:0] out_data;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   rxaddr_filter uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_addr (cfg_addr),
      .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata),
      .ch_valid (ch_valid),
      .ch_data  (ch_data),
      .out_valid(out_valid),
      .out_data (out_data)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read(input string req, input logic [1:0] a, input logic [7:0] exp);
      @(negedge clk);
      cfg_addr = a;
      #1;
      chk(req, cfg_rdata, exp);
   endtask

   task automatic send(input string req, input logic [7:0] d, input bit exp_v);
      @(negedge clk);
      ch_valid = 1'b1; ch_data = d;
      @(negedge clk);
      ch_valid = 1'b0;
      chk(req, {7'd0, out_valid}, {7'd0, exp_v});
      if (exp_v) chk(req, out_data, d);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      bit pm;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 out_valid", {7'd0, out_valid}, 8'h00);
      cfg_read("R1 match0", 2'd0, 8'h00);
      cfg_read("R1 match1", 2'd1, 8'h00);
      cfg_read("R1 enables", 2'd2, 8'h00);

      // R2: register access
      cfg_write(2'd0, M0);
      cfg_write(2'd1, M1);
      cfg_write(2'd2, 8'hFF);
      cfg_read("R2 match0", 2'd0, M0);
      cfg_read("R2 match1", 2'd1, M1);
      cfg_read("R2 enables", 2'd2, 8'h03);
      cfg_read("R2 unused address", 2'd3, 8'h00);

      // R7: gate closed after reset with enables set
      cfg_write(2'd2, 8'h01);
      send("R7 data before address", 8'h11, 1'b0);
      send("R7 data before address", 8'h12, 1'b0);
      send("R4 match0 address", M0, 1'b1);
      // R6: persistence over several data characters
      send("R6 data after match", 8'h22, 1'b1);
      send("R6 data after match", 8'h23, 1'b1);
      send("R6 data after match", 8'h7F, 1'b1);
      send("R5 non-matching address", 8'h81, 1'b0);
      send("R6 data after miss", 8'h24, 1'b0);
      send("R6 data after miss", 8'h00, 1'b0);
      // R10: idle cycle shows no output
      @(negedge clk);
      chk("R10 idle", {7'd0, out_valid}, 8'h00);

      // R3 R4 R5 R6: sweep all address codes under all enable patterns
      pm = 1'b0;
      for (int e = 0; e < 4; e++) begin
         cfg_write(2'd2, 8'(e));
         for (int a = 128; a < 256; a++) begin
            bit h;
            h = (e[0] && a == int'(M0)) || (e[1] && a == int'(M1));
            if (e == 0) begin
               send("R3 bypass address", 8'(a), 1'b1);
               send("R3 bypass data", 8'(a - 128), 1'b1);
            end else begin
               pm = h;
               send(h ? "R4 sweep address" : "R5 sweep address", 8'(a), h);
               send("R6 sweep data", 8'(a - 128), pm);
            end
         end
      end

      // R9: state held across bypass
      cfg_write(2'd2, 8'h03);
      send("R4 open gate", M1, 1'b1);
      cfg_write(2'd2, 8'h00);
      send("R9 bypass non-match", 8'h81, 1'b1);
      cfg_write(2'd2, 8'h03);
      send("R9 state kept pass", 8'h31, 1'b1);
      send("R5 close gate", 8'h81, 1'b0);
      cfg_write(2'd2, 8'h00);
      send("R9 bypass match", M0, 1'b1);
      cfg_write(2'd2, 8'h03);
      send("R9 state kept drop", 8'h32, 1'b0);

      // R8: write in the same cycle as a character
      cfg_write(2'd2, 8'h01);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 8'h90;
      ch_valid = 1'b1; ch_data = 8'h90;
      @(negedge clk);
      cfg_we = 1'b0; ch_valid = 1'b0;
      chk("R8 old value used", {7'd0, out_valid}, 8'h00);
      send("R8 new value used", 8'h90, 1'b1);
      send("R8 old value gone", M0, 1'b0);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule